// File: doc/BRIEF.md
# ECC error status capture unit

This unit collects uncorrectable ECC error reports from two memories, an internal RAM and a flash array. It keeps them in a small status register that drives a single interrupt request. Each source has its own capture set, which holds the faulting address, the access attributes and the data word. A reportable event reloads that capture set, so the captured contents always describe the flag that is currently raised.

Only one flag can be raised at a time. A newer reportable event replaces whatever is pending, and the RAM source wins a same-cycle tie. Software reads the status and the capture registers over a single-cycle register port, and clears a flag by writing a one to it. The safe service sequence has four steps: read the status, read the captures, read the status again, and repeat the sequence if the two status reads differ.

Top module: `ecc_err_capture`

## Requirements
- R1: At most one status flag is set at any time. A reportable event from either source clears the other flag in the same update.
- R2: A reportable event loads the capture set of its own source, and the values are visible one cycle later. The register offsets are 1 for RAM address, 2 for RAM attributes, 3 for RAM data, 4 for flash address, 5 for flash attributes and 6 for flash data. Offset 7 reads zero.
- R3: When both sources report in the same cycle, only the RAM event is recorded. The flash flag stays clear and the flash capture set keeps its old contents.
- R4: The status register is read at offset 0. Its 8-bit value places the RAM flag in bit 1 and the flash flag in bit 0, with LSB-first numbering. These are positions 6 and 7 when the 8-bit register is numbered MSB-first. Bits 7:2 and all higher read-data bits read as zero.
- R5: A write to offset 0 clears each set flag whose write-data bit is 1. A flag whose write-data bit is 0 is unchanged.
- R6: `irq_o` is high exactly while a status flag is set.
- R7: After reset all flags and all capture registers read zero, and `irq_o` is low.
- R8: An event from a source whose enable input is low changes neither the flags nor any capture register.
- R9: If a clearing write and a reportable event meet in the same cycle, the event wins. Its flag is set and its capture set is reloaded.
- R10: Capture registers keep their values after their flag is cleared, and after the other source reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ram_en_i | input | 1 | Reporting enable for RAM events |
| ram_evt_i | input | 1 | RAM uncorrectable error pulse |
| ram_addr_i | input | ADDR_W | RAM faulting address |
| ram_attr_i | input | ATTR_W | RAM access attributes |
| ram_data_i | input | DATA_W | RAM data word |
| flash_en_i | input | 1 | Reporting enable for flash events |
| flash_evt_i | input | 1 | Flash uncorrectable error pulse |
| flash_addr_i | input | ADDR_W | Flash faulting address |
| flash_attr_i | input | ATTR_W | Flash access attributes |
| flash_data_i | input | DATA_W | Flash data word |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register offset |
| reg_wdata_i | input | REG_DW | Register write data |
| reg_rdata_o | output | REG_DW | Register read data, combinational from offset |
| irq_o | output | 1 | ECC interrupt request |

## Verification
The properties assume that every event input and enable input holds a known value after reset is released. They also assume that the source data is valid in the cycle its event pulse is high, and that `reg_addr_i` is never unknown. The stimulus meets these assumptions in three ways. It changes every input only on the falling clock edge. It keeps each payload stable for the whole event cycle. It holds the register offset at a defined value, so the combinational read data can be compared with a cycle-exact model on every clock. The clearing-write race and the same-cycle source tie are driven on purpose, which exercises the precedence properties.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
    localparam int NSRC           = 2;
    localparam int SRC_RAM        = 0;
    localparam int SRC_FLASH      = 1;
    localparam int STAT_W         = 2;
    localparam int STAT_RAM_BIT   = 1;
    localparam int STAT_FLASH_BIT = 0;

    localparam int OFF_STATUS   = 0;
    localparam int OFF_RAM_ADDR = 1;
    localparam int OFF_RAM_ATTR = 2;
    localparam int OFF_RAM_DATA = 3;
    localparam int OFF_FL_ADDR  = 4;
    localparam int OFF_FL_ATTR  = 5;
    localparam int OFF_FL_DATA  = 6;
endpackage

// File: rtl/ecc_src_select.sv
module ecc_src_select
    import ecc_cap_pkg::*;
(
    input  logic            ram_en_i,
    input  logic            ram_evt_i,
    input  logic            flash_en_i,
    input  logic            flash_evt_i,
    output logic [NSRC-1:0] load_o
);
    logic ram_hit;
    logic fl_hit;

    always_comb begin
        ram_hit           = ram_en_i & ram_evt_i;
        fl_hit            = flash_en_i & flash_evt_i;
        load_o            = '0;
        load_o[SRC_RAM]   = ram_hit;
        load_o[SRC_FLASH] = fl_hit & ~ram_hit;
    end
endmodule

// File: rtl/ecc_capture_set.sv
module ecc_capture_set #(
    parameter int ADDR_W = 32,
    parameter int ATTR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ATTR_W-1:0] attr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ATTR_W-1:0] attr_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ATTR_W-1:0] attr;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (load_i) begin
            cap_d.addr = addr_i;
            cap_d.attr = attr_i;
            cap_d.data = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign addr_o = cap_q.addr;
    assign attr_o = cap_q.attr;
    assign data_o = cap_q.data;
endmodule

// File: rtl/ecc_flag_reg.sv
module ecc_flag_reg
    import ecc_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   load_i,
    input  logic              clr_i,
    input  logic [STAT_W-1:0] clr_mask_i,
    output logic [STAT_W-1:0] flags_o
);
    typedef struct packed {
        logic [STAT_W-1:0] flags;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i[SRC_RAM]) begin
            st_d.flags               = '0;
            st_d.flags[STAT_RAM_BIT] = 1'b1;
        end else if (load_i[SRC_FLASH]) begin
            st_d.flags                 = '0;
            st_d.flags[STAT_FLASH_BIT] = 1'b1;
        end else if (clr_i) begin
            st_d.flags = st_q.flags & ~clr_mask_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
    import ecc_cap_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ATTR_W = 8,
    parameter int DATA_W = 32,
    parameter int REG_DW = 32,
    parameter int REG_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ram_en_i,
    input  logic              ram_evt_i,
    input  logic [ADDR_W-1:0] ram_addr_i,
    input  logic [ATTR_W-1:0] ram_attr_i,
    input  logic [DATA_W-1:0] ram_data_i,
    input  logic              flash_en_i,
    input  logic              flash_evt_i,
    input  logic [ADDR_W-1:0] flash_addr_i,
    input  logic [ATTR_W-1:0] flash_attr_i,
    input  logic [DATA_W-1:0] flash_data_i,
    input  logic              reg_wr_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [REG_DW-1:0] reg_wdata_i,
    output logic [REG_DW-1:0] reg_rdata_o,
    output logic              irq_o
);
    logic [NSRC-1:0]              load;
    logic [NSRC-1:0][ADDR_W-1:0]  src_addr, cap_addr;
    logic [NSRC-1:0][ATTR_W-1:0]  src_attr, cap_attr;
    logic [NSRC-1:0][DATA_W-1:0]  src_data, cap_data;
    logic [STAT_W-1:0]            flags_q;
    logic                         stat_wr;
    logic                         wdata_unused;

    assign src_addr[SRC_RAM]   = ram_addr_i;
    assign src_attr[SRC_RAM]   = ram_attr_i;
    assign src_data[SRC_RAM]   = ram_data_i;
    assign src_addr[SRC_FLASH] = flash_addr_i;
    assign src_attr[SRC_FLASH] = flash_attr_i;
    assign src_data[SRC_FLASH] = flash_data_i;

    assign stat_wr      = reg_wr_i && (reg_addr_i == REG_AW'(OFF_STATUS));
    assign wdata_unused = ^reg_wdata_i[REG_DW-1:STAT_W];

    ecc_src_select u_sel (
        .ram_en_i    (ram_en_i),
        .ram_evt_i   (ram_evt_i),
        .flash_en_i  (flash_en_i),
        .flash_evt_i (flash_evt_i),
        .load_o      (load)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_cap
        ecc_capture_set #(
            .ADDR_W (ADDR_W),
            .ATTR_W (ATTR_W),
            .DATA_W (DATA_W)
        ) u_cap (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load[g]),
            .addr_i (src_addr[g]),
            .attr_i (src_attr[g]),
            .data_i (src_data[g]),
            .addr_o (cap_addr[g]),
            .attr_o (cap_attr[g]),
            .data_o (cap_data[g])
        );
    end

    ecc_flag_reg u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .clr_i      (stat_wr),
        .clr_mask_i (reg_wdata_i[STAT_W-1:0]),
        .flags_o    (flags_q)
    );

    always_comb begin
        reg_rdata_o = '0;
        case (int'(reg_addr_i))
            OFF_STATUS:   reg_rdata_o = REG_DW'(flags_q);
            OFF_RAM_ADDR: reg_rdata_o = REG_DW'(cap_addr[SRC_RAM]);
            OFF_RAM_ATTR: reg_rdata_o = REG_DW'(cap_attr[SRC_RAM]);
            OFF_RAM_DATA: reg_rdata_o = REG_DW'(cap_data[SRC_RAM]);
            OFF_FL_ADDR:  reg_rdata_o = REG_DW'(cap_addr[SRC_FLASH]);
            OFF_FL_ATTR:  reg_rdata_o = REG_DW'(cap_attr[SRC_FLASH]);
            OFF_FL_DATA:  reg_rdata_o = REG_DW'(cap_data[SRC_FLASH]);
            default:      reg_rdata_o = '0;
        endcase
    end

    assign irq_o = |flags_q;
endmodule

// File: rtl/ecc_err_capture_chk.sv
module ecc_err_capture_chk #(
    parameter int ADDR_W = 32,
    parameter int REG_DW = 32,
    parameter int REG_AW = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ram_en_i,
    input logic              ram_evt_i,
    input logic [ADDR_W-1:0] ram_addr_i,
    input logic              flash_en_i,
    input logic              flash_evt_i,
    input logic              reg_wr_i,
    input logic [REG_AW-1:0] reg_addr_i,
    input logic [1:0]        wclr,
    input logic [REG_DW-1:0] reg_rdata_o,
    input logic              irq_o,
    input logic [1:0]        flags,
    input logic [ADDR_W-1:0] ram_cap_addr,
    input logic [ADDR_W-1:0] fl_cap_addr
);
    logic ram_hit, fl_hit, at_stat;
    assign ram_hit = ram_en_i && ram_evt_i;
    assign fl_hit  = flash_en_i && flash_evt_i;
    assign at_stat = (reg_addr_i == '0);

    // R1
    one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags));

    // R1
    flash_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_hit && !ram_hit) |=> (flags == 2'b01));

    // R3
    ram_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_hit |=> (flags == 2'b10));

    // R3
    fl_cap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_hit |=> $stable(fl_cap_addr));

    // R2
    ram_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_hit |=> (ram_cap_addr == $past(ram_addr_i)));

    // R4
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_stat |-> (reg_rdata_o[REG_DW-1:2] == '0));

    // R6
    irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_stat |-> (irq_o == (reg_rdata_o[1:0] != 2'b00)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_hit && !fl_hit && !reg_wr_i) |=> $stable(flags));

    // R5
    w0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_hit && !fl_hit && reg_wr_i && at_stat && wclr == 2'b00) |=> $stable(flags));

    // R9
    clr_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_hit && reg_wr_i && at_stat && wclr[1]) |=> flags[1]);
endmodule

bind ecc_err_capture ecc_err_capture_chk #(
    .ADDR_W (ADDR_W),
    .REG_DW (REG_DW),
    .REG_AW (REG_AW)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ram_en_i     (ram_en_i),
    .ram_evt_i    (ram_evt_i),
    .ram_addr_i   (ram_addr_i),
    .flash_en_i   (flash_en_i),
    .flash_evt_i  (flash_evt_i),
    .reg_wr_i     (reg_wr_i),
    .reg_addr_i   (reg_addr_i),
    .wclr         (reg_wdata_i[1:0]),
    .reg_rdata_o  (reg_rdata_o),
    .irq_o        (irq_o),
    .flags        (flags_q),
    .ram_cap_addr (cap_addr[0]),
    .fl_cap_addr  (cap_addr[1])
);

// File: tb/ecc_err_capture_tb.sv
`timescale 1ns/1ps
module ecc_err_capture_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ram_en = 1'b1, ram_evt = 1'b0;
    logic [31:0] ram_addr = '0, ram_data = '0;
    logic [7:0]  ram_attr = '0;
    logic        flash_en = 1'b1, flash_evt = 1'b0;
    logic [31:0] flash_addr = '0, flash_data = '0;
    logic [7:0]  flash_attr = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [31:0] m_reg [0:7];

    always #2.5 clk = ~clk;

    ecc_err_capture dut_i (
        .clk(clk), .rst_n(rst_n),
        .ram_en_i(ram_en), .ram_evt_i(ram_evt), .ram_addr_i(ram_addr),
        .ram_attr_i(ram_attr), .ram_data_i(ram_data),
        .flash_en_i(flash_en), .flash_evt_i(flash_evt), .flash_addr_i(flash_addr),
        .flash_attr_i(flash_attr), .flash_data_i(flash_data),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .irq_o(irq)
    );

    function automatic logic [7:0] attr_of(input logic [31:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction
    function automatic logic [31:0] data_of(input logic [31:0] a);
        return ~a;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // behavioural reference: one register image, updated per clock
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_reg[i] <= '0;
        end else if (ram_evt && ram_en) begin
            m_reg[0] <= 32'd2;
            m_reg[1] <= ram_addr;
            m_reg[2] <= {24'h0, ram_attr};
            m_reg[3] <= ram_data;
        end else if (flash_evt && flash_en) begin
            m_reg[0] <= 32'd1;
            m_reg[4] <= flash_addr;
            m_reg[5] <= {24'h0, flash_attr};
            m_reg[6] <= flash_data;
        end else if (reg_wr && reg_addr == 3'd0) begin
            m_reg[0] <= m_reg[0] & ~reg_wdata;
        end
    end

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk("R6 irq per cycle", {31'h0, irq}, {31'h0, (m_reg[0] != 0)});
            chk("R2/R4 read per cycle", reg_rdata, m_reg[reg_addr]);
        end
    end

    task automatic fire(input bit r, input bit f, input bit w, input logic [31:0] wd,
                        input logic [31:0] ra, input logic [31:0] fa);
        @(negedge clk);
        ram_evt = r; ram_addr = ra; ram_attr = attr_of(ra); ram_data = data_of(ra);
        flash_evt = f; flash_addr = fa; flash_attr = attr_of(fa); flash_data = data_of(fa);
        reg_wr = w; reg_addr = 3'd0; reg_wdata = wd;
        @(negedge clk);
        ram_evt = 1'b0; flash_evt = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic rchk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] s1, s2, c1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R7 reset state
        rchk("R7 status after reset", 3'd0, 32'h0);
        rchk("R7 ram addr after reset", 3'd1, 32'h0);
        rchk("R7 flash data after reset", 3'd6, 32'h0);
        chk("R7 irq after reset", {31'h0, irq}, 32'h0);

        // R2 RAM capture, R4 layout, R6 irq
        fire(1, 0, 0, 0, 32'h0000_1A40, 0);
        rchk("R4 ram flag bit1", 3'd0, 32'h2);
        rchk("R2 ram addr", 3'd1, 32'h0000_1A40);
        rchk("R2 ram attr", 3'd2, {24'h0, attr_of(32'h0000_1A40)});
        rchk("R2 ram data", 3'd3, data_of(32'h0000_1A40));
        chk("R6 irq high", {31'h0, irq}, 32'h1);

        // R1 replacement by flash, R10 RAM captures retained
        fire(0, 1, 0, 0, 0, 32'h00F0_0008);
        rchk("R1 flash replaces ram", 3'd0, 32'h1);
        rchk("R2 flash addr", 3'd4, 32'h00F0_0008);
        rchk("R2 flash data", 3'd6, data_of(32'h00F0_0008));
        rchk("R10 ram addr kept", 3'd1, 32'h0000_1A40);

        // R5 write-zero and write to clear bit
        fire(0, 0, 1, 32'h0, 0, 0);
        rchk("R5 write zero no effect", 3'd0, 32'h1);
        fire(0, 0, 1, 32'h2, 0, 0);
        rchk("R5 clear of unset bit", 3'd0, 32'h1);
        fire(0, 0, 1, 32'h1, 0, 0);
        rchk("R5 flash cleared", 3'd0, 32'h0);
        chk("R6 irq low after clear", {31'h0, irq}, 32'h0);
        rchk("R10 flash addr kept after clear", 3'd4, 32'h00F0_0008);

        // R3 same-cycle tie
        fire(1, 1, 0, 0, 32'h0000_2B00, 32'h00F0_1230);
        rchk("R3 ram wins tie", 3'd0, 32'h2);
        rchk("R3 ram addr loaded", 3'd1, 32'h0000_2B00);
        rchk("R3 flash addr untouched", 3'd4, 32'h00F0_0008);
        fire(0, 0, 1, 32'h2, 0, 0);

        // R8 disabled sources
        @(negedge clk); ram_en = 1'b0; flash_en = 1'b0;
        fire(1, 0, 0, 0, 32'h0000_3C00, 0);
        rchk("R8 disabled ram no flag", 3'd0, 32'h0);
        rchk("R8 disabled ram no capture", 3'd1, 32'h0000_2B00);
        fire(0, 1, 0, 0, 0, 32'h00F0_4440);
        rchk("R8 disabled flash no capture", 3'd4, 32'h00F0_0008);
        chk("R8 irq stays low", {31'h0, irq}, 32'h0);
        @(negedge clk); ram_en = 1'b1; flash_en = 1'b1;

        // R9 clear racing a new event
        fire(1, 0, 0, 0, 32'h0000_4D00, 0);
        fire(1, 0, 1, 32'h2, 32'h0000_5E00, 0);
        rchk("R9 event beats clear", 3'd0, 32'h2);
        rchk("R9 captures reloaded", 3'd1, 32'h0000_5E00);
        fire(0, 0, 1, 32'h2, 0, 0);

        // R1 service loop with an event between status reads
        fire(1, 0, 0, 0, 32'h0000_6F00, 0);
        rd(3'd0, s1);
        rd(3'd1, c1);
        fire(0, 1, 0, 0, 0, 32'h00F0_7770);
        rd(3'd0, s2);
        chk("R1 status reads differ", {31'h0, (s1 != s2)}, 32'h1);
        chk("R1 first read ram", s1, 32'h2);
        chk("R1 second read flash", s2, 32'h1);
        chk("R2 first capture ram", c1, 32'h0000_6F00);
        rchk("R2 newer flash capture", 3'd4, 32'h00F0_7770);
        rchk("R2 newer flash attr", 3'd5, {24'h0, attr_of(32'h00F0_7770)});
        fire(0, 0, 1, s2, 0, 0);
        chk("R6 irq low after service", {31'h0, irq}, 32'h0);

        // R4 reserved bits
        fire(1, 0, 0, 0, 32'h0000_8000, 0);
        fire(0, 0, 1, 32'hFFFF_FFFC, 0, 0);
        rchk("R4 R5 reserved write ignored", 3'd0, 32'h2);
        rchk("R2 unused offset reads zero", 3'd7, 32'h0);

        @(negedge clk); reg_addr = 3'd0;
        repeat (2) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule